// File: doc/BRIEF.md
# Constant-Rate Packet Slot Scheduler

This block paces the transmit side of a point-to-point packetized memory link. Link time is cut into fixed slots. Exactly one packet leaves in every slot, whatever the real traffic is. Real packets from an upstream producer wait in a small queue and take the next free slot. When the queue is empty at a slot, the block sends a dummy packet of the same width instead. An observer on the link therefore sees a steady beat that carries no information about when real demand occurred.

Each link packet is one bit wider than the payload. The most significant bit is a real/dummy marker, and it sits inside the packet body that a later stage encrypts. A dummy carries marker 0 and an all-zero payload. The same top also holds the receive-side filter for the opposite direction of the link. The filter forwards packets whose marker is 1 and silently drops dummies.

The slot interval is a static setting. It resets to 70 cycles and can be written to any value from 8 to 700 cycles. A write never cuts the slot in progress short.

The producer interface follows valid/ready. A packet transfers on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops while the queue is full. A producer may drop or change its offer while stalled, and a stalled offer is never taken. The consumer interface has no back-pressure, because the link cannot be stalled. The consumer must take `out_data` in every cycle where `out_valid` is high.

Top module: `slot_pacer`

## Requirements
- R1: During reset and right after it, `link_valid`=0, `out_valid`=0 and `in_ready`=1. With the default interval N=70, the first slot is the rising edge N cycles after reset release. Later slots follow every interval. `link_valid` is high for exactly the one cycle after each slot edge and is never high at any other time, whatever the traffic is.
- R2: A slot with an empty queue sends a dummy, which is `link_pkt` = {1'b0, PAY_W zero bits}: the same width as a real packet.
- R3: A slot with a non-empty queue removes the oldest packet and sends {1'b1, payload}. At most one packet leaves per slot, packets leave in arrival order, and `link_pkt` holds its value between slots.
- R4: `in_ready` is low exactly while FIFO_DEPTH (default 4) packets are queued. A packet offered while `in_ready` is low is not taken and never appears on the link.
- R5: A receive beat with `rx_valid`=1 and marker bit `rx_pkt[PAY_W]`=1 produces `out_valid`=1 with `out_data`=`rx_pkt[PAY_W-1:0]` one cycle later. A beat with marker 0 produces no output.
- R6: A written interval below 8 is stored as 8, and one above 700 is stored as 700.
- R7: An interval written with `cfg_wr`=1 first governs the slot interval that starts at the next slot boundary. The interval in progress completes with its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Interval write strobe |
| cfg_interval | input | 10 | Requested slot interval in cycles |
| in_valid | input | 1 | Producer offers a real packet |
| in_ready | output | 1 | Queue can accept a packet |
| in_data | input | PAY_W | Real packet payload |
| link_valid | output | 1 | One-cycle strobe marking a slot |
| link_pkt | output | PAY_W+1 | Slot packet: marker bit on top, payload below |
| rx_valid | input | 1 | Receive-side link beat |
| rx_pkt | input | PAY_W+1 | Receive-side link packet |
| out_valid | output | 1 | Real packet delivered to consumer |
| out_data | output | PAY_W | Delivered payload |

## Verification
A slot counter that has drifted or reloaded wrongly shows up at the next slot as a `link_valid` strobe on the wrong edge. The bench compares every cycle against a spec-level model, so such a fault is caught within one interval. A queue whose pointers or level are off shows up as a wrong payload, a wrong order, or a real/dummy swap at the next slot, or as `in_ready` disagreeing with the modelled occupancy on the very next cycle. A shadow interval applied too early or too late shows up as one wrong gap between slots right after the write.

// File: rtl/slot_pkg.sv
package slot_pkg;
  localparam int INTERVAL_W   = 10;
  localparam int INTERVAL_MIN = 8;
  localparam int INTERVAL_MAX = 700;
  localparam int INTERVAL_DEF = 70;

  typedef logic [INTERVAL_W-1:0] interval_t;

  function automatic interval_t clamp_interval(input interval_t v);
    if (v < interval_t'(INTERVAL_MIN)) return interval_t'(INTERVAL_MIN);
    if (v > interval_t'(INTERVAL_MAX)) return interval_t'(INTERVAL_MAX);
    return v;
  endfunction
endpackage

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  output logic         push_ready,
  input  logic [W-1:0] push_data,
  input  logic         pop_en,
  output logic         head_valid,
  output logic [W-1:0] head_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] level;
  logic          do_push, do_pop;

  assign push_ready = (level != LW'(DEPTH));
  assign head_valid = (level != '0);
  assign head_data  = store[rd_ptr];
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop_en && head_valid;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (do_push && wr_ptr == AW'(i)) store[i] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  // R4
  fifo_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R3
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> head_valid);
endmodule

// File: rtl/slot_timer.sv
module slot_timer
  import slot_pkg::*;
#(
  parameter int DEF = INTERVAL_DEF
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_wr,
  input  interval_t cfg_val,
  output logic      tick
);
  interval_t cnt, active, pending, wr_val;

  assign wr_val = clamp_interval(cfg_val);
  assign tick   = (cnt == active - interval_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      active  <= interval_t'(DEF);
      pending <= interval_t'(DEF);
    end else begin
      if (cfg_wr) pending <= wr_val;
      if (tick) begin
        cnt    <= '0;
        active <= cfg_wr ? wr_val : pending;
      end else begin
        cnt <= cnt + interval_t'(1);
      end
    end
  end

  // R6
  interval_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active >= interval_t'(INTERVAL_MIN)) && (active <= interval_t'(INTERVAL_MAX)));

  // R7
  interval_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(active));
endmodule

// File: rtl/slot_framer.sv
module slot_framer #(
  parameter int PAY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             head_valid,
  input  logic [PAY_W-1:0] head_data,
  output logic             pop_en,
  output logic             link_valid,
  output logic [PAY_W:0]   link_pkt
);
  assign pop_en = tick && head_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_valid <= 1'b0;
      link_pkt   <= '0;
    end else begin
      link_valid <= tick;
      if (tick) link_pkt <= head_valid ? {1'b1, head_data} : {1'b0, {PAY_W{1'b0}}};
    end
  end

  // R1
  slot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid |=> !link_valid);

  // R2
  dummy_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid && !link_pkt[PAY_W]) |-> (link_pkt[PAY_W-1:0] == '0) && !$past(head_valid));

  // R3
  real_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid && link_pkt[PAY_W]) |-> $past(head_valid));
endmodule

// File: rtl/dummy_filter.sv
module dummy_filter #(
  parameter int PAY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [PAY_W:0]   rx_pkt,
  output logic             out_valid,
  output logic [PAY_W-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= rx_valid && rx_pkt[PAY_W];
      if (rx_valid && rx_pkt[PAY_W]) out_data <= rx_pkt[PAY_W-1:0];
    end
  end

  // R5
  drop_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(rx_valid) && $past(rx_pkt[PAY_W]));
endmodule

// File: rtl/slot_pacer.sv
module slot_pacer #(
  parameter int PAY_W        = 32,
  parameter int FIFO_DEPTH   = 4,
  parameter int DEF_INTERVAL = slot_pkg::INTERVAL_DEF
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_wr,
  input  logic [slot_pkg::INTERVAL_W-1:0] cfg_interval,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [PAY_W-1:0]                in_data,
  output logic                            link_valid,
  output logic [PAY_W:0]                  link_pkt,
  input  logic                            rx_valid,
  input  logic [PAY_W:0]                  rx_pkt,
  output logic                            out_valid,
  output logic [PAY_W-1:0]                out_data
);
  logic             tick, pop_en, head_valid;
  logic [PAY_W-1:0] head_data;

  pkt_fifo #(.W(PAY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_valid(in_valid), .push_ready(in_ready), .push_data(in_data),
    .pop_en(pop_en), .head_valid(head_valid), .head_data(head_data)
  );

  slot_timer #(.DEF(DEF_INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_val(cfg_interval), .tick(tick)
  );

  slot_framer #(.PAY_W(PAY_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .head_valid(head_valid), .head_data(head_data), .pop_en(pop_en),
    .link_valid(link_valid), .link_pkt(link_pkt)
  );

  dummy_filter #(.PAY_W(PAY_W)) u_filter (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_pkt(rx_pkt),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: tb/slot_pacer_test.sv
module slot_pacer_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = CLK_PERIOD / 4;
  localparam int PAY_W      = 32;
  localparam int DEPTH      = 4;
  localparam int DEF_N      = 70;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_wr = 1'b0;
  logic [9:0]       cfg_interval = '0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [PAY_W-1:0] in_data = '0;
  logic             link_valid;
  logic [PAY_W:0]   link_pkt;
  logic             out_valid;
  logic [PAY_W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int ecnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_pacer uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_interval(cfg_interval),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .link_valid(link_valid), .link_pkt(link_pkt),
    .rx_valid(link_valid), .rx_pkt(link_pkt),
    .out_valid(out_valid), .out_data(out_data)
  );

  always @(posedge clk) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  function automatic int clampv(input int v);
    if (v < 8)   return 8;
    if (v > 700) return 700;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at edge %0d", req, what, act, exp, ecnt);
    end
  endtask

  // Spec-level model, evaluated at each falling edge for the rising edge just passed.
  logic [PAY_W-1:0] mq[$];
  int               m_next, m_active, m_pending;
  bit               s_valid, s_wr;
  logic [PAY_W-1:0] s_data;
  int               s_wdata;
  bit               prev_real;
  logic [PAY_W-1:0] prev_pay;

  always @(negedge clk) begin
    if (!rst_n || ecnt == 0) begin
      mq.delete();
      m_next = DEF_N; m_active = DEF_N; m_pending = DEF_N;
      prev_real = 0; prev_pay = '0;
    end else begin
      bit exp_slot, exp_real;
      logic [PAY_W-1:0] exp_pay;
      int old_size;
      exp_slot = (ecnt == m_next);
      exp_real = 0;
      exp_pay  = '0;
      old_size = mq.size();
      if (s_wr) m_pending = clampv(s_wdata);
      if (exp_slot) begin
        if (old_size > 0) begin exp_real = 1; exp_pay = mq.pop_front(); end
        m_active = m_pending;
        m_next   = ecnt + m_active;
      end
      if (s_valid && old_size < DEPTH) mq.push_back(s_data);
      chk(link_valid == exp_slot, "R1", "link_valid", 64'(link_valid), 64'(exp_slot));
      if (exp_slot)
        chk(link_pkt == {exp_real, exp_pay}, exp_real ? "R3" : "R2", "link_pkt",
            64'(link_pkt), 64'({exp_real, exp_pay}));
      chk(out_valid == prev_real, "R5", "out_valid", 64'(out_valid), 64'(prev_real));
      if (prev_real)
        chk(out_data == prev_pay, "R5", "out_data", 64'(out_data), 64'(prev_pay));
      chk(in_ready == (mq.size() < DEPTH), "R4", "in_ready", 64'(in_ready), 64'(mq.size() < DEPTH));
      prev_real = exp_slot && exp_real;
      prev_pay  = exp_pay;
    end
    s_valid = in_valid; s_data = in_data; s_wr = cfg_wr; s_wdata = int'(cfg_interval);
  end

  task automatic step();
    @(posedge clk); #(Q);
  endtask

  task automatic write_interval(input int v);
    step(); cfg_wr = 1'b1; cfg_interval = 10'(v);
    step(); cfg_wr = 1'b0;
  endtask

  task automatic wait_slot(output int e);
    do @(negedge clk); while (!link_valid);
    e = ecnt;
  endtask

  task automatic random_traffic(input int cycles, input int one_in);
    for (int i = 0; i < cycles; i++) begin
      step();
      in_valid = (($urandom % one_in) == 0);
      in_data  = $urandom;
    end
    step(); in_valid = 1'b0;
  endtask

  initial begin
    int e0, e1, e2, seen;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(link_valid == 1'b0, "R1", "reset link_valid", 64'(link_valid), 64'd0);
    chk(out_valid == 1'b0, "R1", "reset out_valid", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R1", "reset in_ready", 64'(in_ready), 64'd1);
    @(posedge clk); #(Q); rst_n = 1'b1;

    // R1 first slot after a full default interval, then idle dummies (R2)
    wait_slot(e0);
    chk(e0 == DEF_N, "R1", "first slot edge", 64'(e0), 64'(DEF_N));
    repeat (150) step();

    // R3 R4 heavy random traffic at the default rate
    random_traffic(3000, 4);

    // R7 a write mid-interval leaves the running interval intact
    wait_slot(e0);
    write_interval(20);
    wait_slot(e1);
    wait_slot(e2);
    chk(e1 - e0 == DEF_N, "R7", "gap before boundary", 64'(e1 - e0), 64'(DEF_N));
    chk(e2 - e1 == 20, "R7", "gap after boundary", 64'(e2 - e1), 64'd20);

    // R6 clamping, low side then high side
    write_interval(3);
    wait_slot(e1);
    wait_slot(e2);
    chk(e2 - e1 == 8, "R6", "clamped low gap", 64'(e2 - e1), 64'd8);
    write_interval(1000);
    wait_slot(e1);
    wait_slot(e2);
    chk(e2 - e1 == 700, "R6", "clamped high gap", 64'(e2 - e1), 64'd700);

    // R4 fill the queue right after a slot, then offer more while full
    for (int i = 0; i < 6; i++) begin
      step(); in_valid = 1'b1; in_data = 32'hA000_0000 + 32'(i);
    end
    step(); in_valid = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b0, "R4", "in_ready when full", 64'(in_ready), 64'd0);
    write_interval(8);
    seen = 0;
    for (int i = 0; i < 820; i++) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    chk(seen == DEPTH, "R4", "delivered after overfill", 64'(seen), 64'(DEPTH));

    // R3 R5 random traffic at the fastest rate
    random_traffic(1500, 3);
    repeat (40) step();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule